// File: doc/BRIEF.md
# Quadrature Up/Down Counter with Reload

This block counts the motion reported by an incremental encoder. Two phase-shifted inputs, A and B, are resynchronised to the system clock and decoded into up and down steps. The decoder offers two resolutions. In the fourfold setting every valid edge of either phase is one step. In the twofold setting only the edges of A count. A single shared value register serves both as the compare target and as the reload value after an underflow. A third input, the index line, can clear the count on its rising edge, can gate counting with its level, or can be ignored.

Software drives the block through a small write/read register port. Through it, software selects the counter length (8 or 16 bits), the resolution, clear-after-compare, reload-on-underflow and the index function. It can also start and stop counting, load or clear the count, and acknowledge the sticky event flags. The interrupt line is high while any flag whose enable is set is high.

The phase decoder is a state machine that holds the last sampled phase. Its states are `PH_INIT` (just out of reset, no phase known yet), `PH_00`, `PH_10`, `PH_11` and `PH_01`, where the suffix is {A,B}. From `PH_INIT` it goes to whichever phase it samples, and that move makes no step. From any phase state, the forward moves `PH_00→PH_10→PH_11→PH_01→PH_00` give an up step. The reverse moves give a down step. A move to the diagonally opposite phase is taken without a step. Staying in the same phase makes no step.

Top module: `qdec_counter`

Register map (`wr_addr`/`rd_addr`):
- 0, control: bit0 length (1 = 16-bit, 0 = 8-bit); bit1 resolution (1 = fourfold, 0 = twofold); bit2 clear-after-compare; bit3 reload-on-underflow; bits5:4 index function (00 off, 01 clear, 10 gate, 11 off); bit6 compare interrupt enable; bit7 overflow interrupt enable; bit8 underflow interrupt enable.
- 1, status: bit0 run (read/write); bit1 compare flag; bit2 overflow flag; bit3 underflow flag; bit4 direction of the last step (1 = up, read only). A write of 0 to a flag bit clears that flag, and a write of 1 leaves it unchanged.
- 2, compare/reload value.
- 3, count. A write loads the count, masked to the selected length.

## Requirements
- R1: After reset the count, control, status and compare/reload registers all read 0 and `irq` is low.
- R2: In fourfold resolution each valid edge of A or B is one step. The step is up when A leads B ({A,B} going 00→10→11→01) and down in the reverse order.
- R3: In twofold resolution only edges of A are counted, with the same direction rule, so four forward phase moves give two counts.
- R4: A sample in which A and B both changed leaves the count unchanged, and decoding continues correctly from the new phase.
- R5: With status bit0 (run) at 0, phase steps leave the count unchanged. The run bit reads back as written.
- R6: An up step at the maximum count (0xFFFF in 16-bit length) wraps the count to 0 and sets the overflow flag (status bit2).
- R7: A down step at count 0 sets the underflow flag (status bit3). The count loads from the compare/reload register when control bit3 is 1, and goes to the maximum count otherwise.
- R8: A step that leaves the count equal to the compare/reload value sets the compare flag (status bit1). With control bit2 set, the next counting event sets the count to 0 instead of stepping it.
- R9: In 8-bit length (control bit0 = 0) the count holds only its low byte, wraps from 0xFF to 0x00 with overflow, and from 0x00 to 0xFF on underflow.
- R10: With index function 01, a rising edge of the index line clears the count. A steady high index does not block counting.
- R11: With index function 10, steps are ignored while the index line is low and counted while it is high.
- R12: Flags are sticky. A status write clears exactly the flags written as 0, and a write to register 3 loads the count.
- R13: `irq` is high exactly when a flag and its enable (control bits 6/7/8 for compare/overflow/underflow) are both 1.
- R14: Status bit4 shows the direction of the last counted step: 1 for up, 0 for down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| index_in | input | 1 | Index line, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on the encoder inputs changing slowly compared with the clock. Each phase or index level must stay put for more than the synchroniser depth plus one cycle, so that every decoded move spans one sample. They also assume that register writes to the count can collide with a counting event. For this reason the count assertions exclude cycles with a count write or an index clear. The stimulus moves one phase at a time and holds each level for five clocks. It issues writes only between steps and drives the simultaneous A/B change deliberately, as a single two-bit jump.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [2:0] {
        PH_INIT = 3'd0,
        PH_00   = 3'd1,
        PH_10   = 3'd2,
        PH_11   = 3'd3,
        PH_01   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        IDX_OFF   = 2'b00,
        IDX_CLEAR = 2'b01,
        IDX_GATE  = 2'b10,
        IDX_RSVD  = 2'b11
    } idx_mode_e;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_STAT   = 2'd1;
    localparam logic [1:0] A_RELOAD = 2'd2;
    localparam logic [1:0] A_COUNT  = 2'd3;

    localparam int CTRL_W     = 9;
    localparam int C_WIDE     = 0;
    localparam int C_X4       = 1;
    localparam int C_CLRCMP   = 2;
    localparam int C_RLDUNF   = 3;
    localparam int C_IDX_LO   = 4;
    localparam int C_IDX_HI   = 5;
    localparam int C_CMP_IE   = 6;
    localparam int C_OVF_IE   = 7;
    localparam int C_UNF_IE   = 8;

    localparam int S_RUN = 0;
    localparam int S_CMP = 1;
    localparam int S_OVF = 2;
    localparam int S_UNF = 3;
    localparam int S_DIR = 4;

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_phase.sv
module qdec_phase
    import qdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    input  logic x4_i,
    output logic step_o,
    output logic up_o
);
    phase_e state_q;
    phase_e phase_now;

    always_comb begin
        unique case ({a_i, b_i})
            2'b00:   phase_now = PH_00;
            2'b10:   phase_now = PH_10;
            2'b11:   phase_now = PH_11;
            default: phase_now = PH_01;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_INIT;
        else        state_q <= phase_now;
    end

    // A-edge moves always step; B-edge moves step only at fourfold resolution.
    always_comb begin
        step_o = 1'b0;
        up_o   = 1'b0;
        unique case (state_q)
            PH_INIT: ;
            PH_00: begin
                if (phase_now == PH_10)      begin step_o = 1'b1; up_o = 1'b1; end
                else if (phase_now == PH_01) begin step_o = x4_i; up_o = 1'b0; end
            end
            PH_10: begin
                if (phase_now == PH_11)      begin step_o = x4_i; up_o = 1'b1; end
                else if (phase_now == PH_00) begin step_o = 1'b1; up_o = 1'b0; end
            end
            PH_11: begin
                if (phase_now == PH_01)      begin step_o = 1'b1; up_o = 1'b1; end
                else if (phase_now == PH_10) begin step_o = x4_i; up_o = 1'b0; end
            end
            PH_01: begin
                if (phase_now == PH_00)      begin step_o = x4_i; up_o = 1'b1; end
                else if (phase_now == PH_11) begin step_o = 1'b1; up_o = 1'b0; end
            end
            default: ;
        endcase
    end

    // R4: a sample where both phases moved never yields a step
    a_r4_no_step_on_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_INIT && a_i != $past(a_i) && b_i != $past(b_i)) |-> !step_o);

    // R3: at twofold resolution a step always coincides with an edge of A
    a_r3_x2_only_a_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_INIT && !x4_i && step_o) |-> (a_i != $past(a_i)));
endmodule

// File: rtl/qdec_core.sv
module qdec_core
    import qdec_pkg::*;
#(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         up_i,
    input  logic         idx_lvl_i,
    input  logic         wide_i,
    input  logic         clr_en_i,
    input  logic         rld_en_i,
    input  idx_mode_e    idx_mode_i,
    input  logic         run_i,
    input  logic [W-1:0] reload_i,
    input  logic         cnt_we_i,
    input  logic [W-1:0] cnt_wdata_i,
    input  logic         stat_we_i,
    input  logic [2:0]   flag_keep_i,
    output logic [W-1:0] count_o,
    output logic         cmp_f_o,
    output logic         ovf_f_o,
    output logic         unf_f_o,
    output logic         dir_o
);
    localparam logic [W-1:0] MAX_WIDE   = '1;
    localparam logic [W-1:0] MAX_NARROW = {{(W-NW){1'b0}}, {NW{1'b1}}};

    logic [W-1:0] count_q, cnt_d, cmax, target;
    logic         pend_q, pend_d, idx_q, dir_d;
    logic         idx_clr, gate_ok, go;
    logic         cmp_set, ovf_set, unf_set;

    assign cmax    = wide_i ? MAX_WIDE : MAX_NARROW;
    assign target  = reload_i & cmax;
    assign idx_clr = (idx_mode_i == IDX_CLEAR) && idx_lvl_i && !idx_q;
    assign gate_ok = (idx_mode_i != IDX_GATE) || idx_lvl_i;
    assign go      = step_i && run_i && gate_ok;

    always_comb begin
        cnt_d   = count_q;
        pend_d  = pend_q;
        dir_d   = dir_o;
        cmp_set = 1'b0;
        ovf_set = 1'b0;
        unf_set = 1'b0;
        if (idx_clr) begin
            cnt_d  = '0;
            pend_d = 1'b0;
        end else if (cnt_we_i) begin
            cnt_d  = cnt_wdata_i;
            pend_d = 1'b0;
        end else if (go) begin
            dir_d = up_i;
            if (pend_q && clr_en_i) begin
                cnt_d  = '0;
                pend_d = 1'b0;
            end else begin
                if (up_i) begin
                    if (count_q == cmax) begin
                        cnt_d   = '0;
                        ovf_set = 1'b1;
                    end else begin
                        cnt_d = count_q + 1'b1;
                    end
                end else begin
                    if (count_q == '0) begin
                        cnt_d   = rld_en_i ? target : cmax;
                        unf_set = 1'b1;
                    end else begin
                        cnt_d = count_q - 1'b1;
                    end
                end
                if ((cnt_d & cmax) == target) begin
                    cmp_set = 1'b1;
                    pend_d  = clr_en_i;
                end
            end
        end
        cnt_d = cnt_d & cmax;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            pend_q  <= 1'b0;
            idx_q   <= 1'b0;
            dir_o   <= 1'b0;
            cmp_f_o <= 1'b0;
            ovf_f_o <= 1'b0;
            unf_f_o <= 1'b0;
        end else begin
            count_q <= cnt_d;
            pend_q  <= pend_d;
            idx_q   <= idx_lvl_i;
            dir_o   <= dir_d;
            cmp_f_o <= ((stat_we_i ? flag_keep_i[0] : 1'b1) & cmp_f_o) | cmp_set;
            ovf_f_o <= ((stat_we_i ? flag_keep_i[1] : 1'b1) & ovf_f_o) | ovf_set;
            unf_f_o <= ((stat_we_i ? flag_keep_i[2] : 1'b1) & unf_f_o) | unf_set;
        end
    end

    assign count_o = count_q;

    // R6: up step at the top of the range wraps to zero with overflow
    a_r6_overflow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (go && up_i && !(pend_q && clr_en_i) && count_q == cmax && !cnt_we_i && !idx_clr)
        |=> (count_q == '0 && ovf_f_o));

    // R7: down step at zero with reload enabled loads the shared value
    a_r7_underflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !up_i && !(pend_q && clr_en_i) && count_q == '0 && rld_en_i && !cnt_we_i && !idx_clr)
        |=> (count_q == ($past(reload_i) & $past(cmax)) && unf_f_o));

    // R8: a pending clear turns the next counting event into a clear
    a_r8_clear_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        (go && pend_q && clr_en_i && !cnt_we_i && !idx_clr) |=> (count_q == '0));

    // R11: a low index line in gate mode freezes the count
    a_r11_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_mode_i == IDX_GATE && !idx_lvl_i && !cnt_we_i && (count_q & cmax) == count_q)
        |=> $stable(count_q));

    // R5: a stopped counter holds its value
    a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_we_i && !idx_clr && (count_q & cmax) == count_q) |=> $stable(count_q));

    // R12: flags stay set until a status write clears them
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_f_o && !stat_we_i) |=> ovf_f_o);
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NARROW_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             index_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    logic [2:0]        sync_out;
    logic              a_s, b_s, idx_s;
    logic              step, up;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic              run_q;
    logic [CNT_W-1:0]  count;
    logic              cmp_f, ovf_f, unf_f, dir;
    logic              cnt_we, stat_we;

    qdec_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({index_in, phase_b, phase_a}),
        .dout (sync_out)
    );
    assign a_s   = sync_out[0];
    assign b_s   = sync_out[1];
    assign idx_s = sync_out[2];

    qdec_phase i_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (a_s),
        .b_i   (b_s),
        .x4_i  (ctrl_q[C_X4]),
        .step_o(step),
        .up_o  (up)
    );

    assign cnt_we  = wr_en && (wr_addr == A_COUNT);
    assign stat_we = wr_en && (wr_addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            run_q    <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:   ctrl_q   <= wr_data[CTRL_W-1:0];
                A_STAT:   run_q    <= wr_data[S_RUN];
                A_RELOAD: reload_q <= wr_data;
                default:  ;
            endcase
        end
    end

    qdec_core #(.W(CNT_W), .NW(NARROW_W)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .up_i       (up),
        .idx_lvl_i  (idx_s),
        .wide_i     (ctrl_q[C_WIDE]),
        .clr_en_i   (ctrl_q[C_CLRCMP]),
        .rld_en_i   (ctrl_q[C_RLDUNF]),
        .idx_mode_i (idx_mode_e'(ctrl_q[C_IDX_HI:C_IDX_LO])),
        .run_i      (run_q),
        .reload_i   (reload_q),
        .cnt_we_i   (cnt_we),
        .cnt_wdata_i(wr_data),
        .stat_we_i  (stat_we),
        .flag_keep_i({wr_data[S_UNF], wr_data[S_OVF], wr_data[S_CMP]}),
        .count_o    (count),
        .cmp_f_o    (cmp_f),
        .ovf_f_o    (ovf_f),
        .unf_f_o    (unf_f),
        .dir_o      (dir)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:   rd_data = CNT_W'(ctrl_q);
            A_STAT:   begin
                rd_data[S_RUN] = run_q;
                rd_data[S_CMP] = cmp_f;
                rd_data[S_OVF] = ovf_f;
                rd_data[S_UNF] = unf_f;
                rd_data[S_DIR] = dir;
            end
            A_RELOAD: rd_data = reload_q;
            default:  rd_data = count;
        endcase
    end

    assign irq = (cmp_f & ctrl_q[C_CMP_IE]) | (ovf_f & ctrl_q[C_OVF_IE]) | (unf_f & ctrl_q[C_UNF_IE]);

    // R13: with every enable off the interrupt stays low
    a_r13_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[C_CMP_IE] && !ctrl_q[C_OVF_IE] && !ctrl_q[C_UNF_IE]) |-> !irq);
endmodule

// File: tb/test_qdec_counter.sv
module test_qdec_counter;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_a = 1'b0, phase_b = 1'b0, index_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    qdec_counter i_qdec_counter (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
        .index_in(index_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] addr, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] addr, output logic [15:0] v);
        @(negedge clk);
        rd_addr = addr;
        #1 v = rd_data;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic set_ph(input int p);
        ph = p % 4;
        phase_a = (ph == 1 || ph == 2);
        phase_b = (ph == 2 || ph == 3);
        settle();
    endtask

    task automatic step_up(input int n);
        for (int i = 0; i < n; i++) set_ph(ph + 1);
    endtask

    task automatic step_dn(input int n);
        for (int i = 0; i < n; i++) set_ph(ph + 3);
    endtask

    task automatic expect_count(input string req, input logic [15:0] exp);
        logic [15:0] v;
        rd(2'd3, v);
        check(req, v, exp);
    endtask

    task automatic expect_stat_bit(input string req, input int bitn, input logic exp);
        logic [15:0] v;
        rd(2'd1, v);
        check(req, {15'd0, v[bitn]}, {15'd0, exp});
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 register reset", v, 16'h0000);
        end
        check("R1 irq reset", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_x4();
        wr(2'd0, 16'h0003); wr(2'd1, 16'h0001); wr(2'd3, 16'h0000);
        step_up(6);
        expect_count("R2 fourfold up", 16'd6);
        expect_stat_bit("R14 direction up", 4, 1'b1);
        step_dn(2);
        expect_count("R2 fourfold down", 16'd4);
        expect_stat_bit("R14 direction down", 4, 1'b0);
    endtask

    task automatic t_x2();
        wr(2'd0, 16'h0001); wr(2'd3, 16'h0000);
        step_up(8);
        expect_count("R3 twofold up", 16'd4);
        step_dn(4);
        expect_count("R3 twofold down", 16'd2);
    endtask

    task automatic t_invalid();
        wr(2'd0, 16'h0003); wr(2'd3, 16'd10);
        set_ph(ph + 2);
        expect_count("R4 jump ignored", 16'd10);
        set_ph(ph + 2);
        expect_count("R4 jump back ignored", 16'd10);
        step_up(1);
        expect_count("R4 decoding resumes", 16'd11);
    endtask

    task automatic t_run();
        wr(2'd1, 16'h0000);
        step_up(3);
        expect_count("R5 stopped holds", 16'd11);
        expect_stat_bit("R5 run reads 0", 0, 1'b0);
        wr(2'd1, 16'h0001);
        step_up(1);
        expect_count("R5 restart counts", 16'd12);
    endtask

    task automatic t_ovf();
        wr(2'd1, 16'h0001); wr(2'd0, 16'h0003); wr(2'd3, 16'hFFFF);
        step_up(1);
        expect_count("R6 wrap to zero", 16'h0000);
        expect_stat_bit("R6 overflow flag", 2, 1'b1);
        wr(2'd1, 16'h0005);
        expect_stat_bit("R12 write 1 keeps flag", 2, 1'b1);
        wr(2'd1, 16'h0001);
        expect_stat_bit("R12 write 0 clears flag", 2, 1'b0);
        wr(2'd3, 16'h1234);
        expect_count("R12 count load", 16'h1234);
    endtask

    task automatic t_unf();
        wr(2'd2, 16'h0100); wr(2'd0, 16'h000B); wr(2'd3, 16'h0000);
        step_dn(1);
        expect_count("R7 reload on underflow", 16'h0100);
        expect_stat_bit("R7 underflow flag", 3, 1'b1);
        wr(2'd0, 16'h0003); wr(2'd3, 16'h0000);
        step_dn(1);
        expect_count("R7 wrap to max", 16'hFFFF);
    endtask

    task automatic t_cmp();
        wr(2'd2, 16'd5); wr(2'd0, 16'h0007); wr(2'd3, 16'd3); wr(2'd1, 16'h0001);
        step_up(2);
        expect_count("R8 reaches compare", 16'd5);
        expect_stat_bit("R8 compare flag", 1, 1'b1);
        step_up(1);
        expect_count("R8 cleared on next event", 16'd0);
        step_up(1);
        expect_count("R8 counts after clear", 16'd1);
        wr(2'd0, 16'h0003); wr(2'd3, 16'd3);
        step_up(3);
        expect_count("R8 no clear when disabled", 16'd6);
    endtask

    task automatic t_narrow();
        wr(2'd1, 16'h0001); wr(2'd0, 16'h0002); wr(2'd3, 16'h12FE);
        expect_count("R9 load masked", 16'h00FE);
        step_up(1);
        expect_count("R9 top of byte", 16'h00FF);
        step_up(1);
        expect_count("R9 wrap to zero", 16'h0000);
        expect_stat_bit("R9 overflow flag", 2, 1'b1);
        step_dn(1);
        expect_count("R9 underflow to 0xFF", 16'h00FF);
    endtask

    task automatic t_idx_clear();
        wr(2'd0, 16'h0013); wr(2'd3, 16'd7);
        index_in = 1'b1; settle();
        expect_count("R10 index edge clears", 16'd0);
        step_up(2);
        expect_count("R10 high index counts", 16'd2);
        index_in = 1'b0; settle();
        expect_count("R10 falling edge no effect", 16'd2);
    endtask

    task automatic t_gate();
        wr(2'd0, 16'h0023); wr(2'd3, 16'd0);
        step_up(2);
        expect_count("R11 gated off", 16'd0);
        index_in = 1'b1; settle();
        step_up(2);
        expect_count("R11 gated on", 16'd2);
        index_in = 1'b0; settle();
    endtask

    task automatic t_irq();
        wr(2'd2, 16'd5); wr(2'd0, 16'h0003); wr(2'd1, 16'h0001); wr(2'd3, 16'hFFFF);
        step_up(1);
        check("R13 flag without enable", {15'd0, irq}, 16'h0000);
        wr(2'd0, 16'h0083);
        #1 check("R13 flag with enable", {15'd0, irq}, 16'h0001);
        wr(2'd1, 16'h0001);
        #1 check("R13 cleared flag", {15'd0, irq}, 16'h0000);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_x4();
        t_x2();
        t_invalid();
        t_run();
        t_ovf();
        t_unf();
        t_cmp();
        t_narrow();
        t_idx_clear();
        t_gate();
        t_irq();
        done = 1;
        summary();
        $finish;
    end
endmodule